// File: doc/BRIEF.md
# Port Input/Output Flag Unit

This unit executes the register-indirect port transfer instructions of an 8-bit processor core, the ones that follow the extended-operation prefix. An issued opcode byte is decoded into one of two kinds. An input instruction waits for the bus side to deliver the byte read from the port. The unit then produces a new flag byte from that data. It also produces a destination register write, which is withheld for the flags-only form, so software can test a port without losing any register. An output instruction selects the byte to drive onto the port: either a register-file entry or, for the zero form, the constant 0x00.

Control is a two-state machine. In `ST_IDLE` the unit accepts `issue_i`. The transition *idle-to-wait* fires on an input opcode. An output opcode takes the transition *idle-to-idle (emit)* and produces its port write pulse one cycle later. In `ST_WAIT_IN` the unit ignores new issues and holds `busy_o` high. The transition *wait-to-idle* fires when `port_rd_valid_i` is seen, and the flag and register results appear in the following cycle. Bus timing and the port address are handled outside this unit.

Top module: `pio_flag_unit`

## Requirements
- R1: After reset `busy_o`, `flags_we_o`, `reg_we_o` and `port_wr_o` are all low.
- R2: An opcode of the form 01_fff_000 (fff = bits 5..3) issued in idle makes `busy_o` high from the next cycle until the cycle after `port_rd_valid_i` is sampled high.
- R3: One cycle after `port_rd_valid_i` is sampled in the wait state, `flags_we_o` pulses for exactly one cycle. In `flags_o`, bit 7 (sign) equals data bit 7 and bit 6 (zero) is set when the data is 0x00.
- R4: On every port input, bit 4 (half carry) and bit 1 (subtract) of `flags_o` are cleared.
- R5: On every port input, bit 2 (parity/overflow) of `flags_o` is set exactly when the data byte holds an even number of ones.
- R6: On every port input, bits 0 (carry), 3 and 5 of `flags_o` equal those bits of `flags_i` as sampled in the issue cycle.
- R7: With the input field fff not equal to 6, `reg_we_o` pulses together with `flags_we_o`, with `reg_sel_o` = fff and `reg_wdata_o` = data. With fff = 6 (flags-only form), `reg_we_o` stays low.
- R8: An opcode of the form 01_fff_001 issued in idle gives a one-cycle `port_wr_o` pulse in the next cycle. `port_wdata_o` equals register fff, where register k occupies bits [8k+7:8k] of `regs_i`.
- R9: With output field fff = 6, `port_wdata_o` is 0x00 whatever `regs_i` holds in slot 6.
- R10: Output instructions never pulse `flags_we_o` or `reg_we_o`.
- R11: An issue while busy, or an opcode matching neither form, produces no output pulse and leaves `busy_o` unchanged.
- R12: `port_rd_valid_i` in idle produces no output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Opcode valid for one cycle |
| opcode_i | input | 8 | Opcode byte following the extended prefix |
| flags_i | input | 8 | Current flag register |
| regs_i | input | 64 | Register file, slot k in bits [8k+7:8k] |
| port_rd_valid_i | input | 1 | Port read data valid |
| port_rd_data_i | input | 8 | Byte read from the port |
| busy_o | output | 1 | Waiting for port read data |
| flags_we_o | output | 1 | Flag register write enable |
| flags_o | output | 8 | New flag value |
| reg_we_o | output | 1 | Destination register write enable |
| reg_sel_o | output | 3 | Destination register index |
| reg_wdata_o | output | 8 | Destination register data |
| port_wr_o | output | 1 | Port write strobe |
| port_wdata_o | output | 8 | Byte driven onto the port |

## Verification
An output instruction's write strobe is due in the cycle after its issue. An input instruction's flag and register results are due in the cycle after the read data is accepted, and `busy_o` rises in the cycle after issue. The driver computes the due cycle of each expected result from a cycle counter and pushes it to a queue. The monitor samples on the falling edge and compares a result only in its due cycle. A pulse in any cycle with no queued result is a failure. This is how the ignored issues, invalid opcodes and stray read strobes are caught.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        K_NONE,
        K_IN,
        K_OUT
    } pio_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT_IN
    } pio_state_e;

    typedef struct packed {
        pio_kind_e  kind;
        logic [2:0] field;
    } pio_dec_t;

    localparam int FLW   = 8;
    localparam int F_CY  = 0;
    localparam int F_SUB = 1;
    localparam int F_PAR = 2;
    localparam int F_X3  = 3;
    localparam int F_HC  = 4;
    localparam int F_X5  = 5;
    localparam int F_ZER = 6;
    localparam int F_SGN = 7;

    localparam logic [2:0] NOREG_FIELD = 3'd6;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic [7:0] opcode_i,
    output pio_dec_t   dec_o
);
    logic group_ok;

    always_comb begin
        group_ok    = (opcode_i[7:6] == 2'b01) && (opcode_i[2:1] == 2'b00);
        dec_o.field = opcode_i[5:3];
        if (!group_ok) begin
            dec_o.kind = K_NONE;
        end else if (opcode_i[0]) begin
            dec_o.kind = K_OUT;
        end else begin
            dec_o.kind = K_IN;
        end
    end
endmodule

// File: rtl/pio_flagcalc.sv
module pio_flagcalc
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [FLW-1:0] old_flags_i,
    input  logic [DW-1:0]  data_i,
    output logic [FLW-1:0] new_flags_o
);
    logic is_zero;
    logic even_par;

    always_comb begin
        is_zero  = (data_i == '0);
        even_par = ~(^data_i);
        new_flags_o        = old_flags_i;
        new_flags_o[F_SGN] = data_i[DW-1];
        new_flags_o[F_ZER] = is_zero;
        new_flags_o[F_HC]  = 1'b0;
        new_flags_o[F_PAR] = even_par;
        new_flags_o[F_SUB] = 1'b0;
    end
endmodule

// File: rtl/pio_outsel.sv
module pio_outsel
    import pio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int SELW = $clog2(NREG)
) (
    input  logic [NREG*DW-1:0] regs_i,
    input  logic [SELW-1:0]    sel_i,
    output logic [DW-1:0]      data_o
);
    logic [DW-1:0] slot [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign slot[k] = regs_i[k*DW +: DW];
    end

    always_comb begin
        if (sel_i == NOREG_FIELD[SELW-1:0]) begin
            data_o = '0;
        end else begin
            data_o = slot[sel_i];
        end
    end
endmodule

// File: rtl/pio_flag_unit.sv
module pio_flag_unit
    import pio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int SELW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [7:0]         opcode_i,
    input  logic [FLW-1:0]     flags_i,
    input  logic [NREG*DW-1:0] regs_i,
    input  logic               port_rd_valid_i,
    input  logic [DW-1:0]      port_rd_data_i,
    output logic               busy_o,
    output logic               flags_we_o,
    output logic [FLW-1:0]     flags_o,
    output logic               reg_we_o,
    output logic [SELW-1:0]    reg_sel_o,
    output logic [DW-1:0]      reg_wdata_o,
    output logic               port_wr_o,
    output logic [DW-1:0]      port_wdata_o
);
    pio_state_e     state, state_nx;
    pio_dec_t       dec;
    logic [SELW-1:0] hold_field;
    logic [FLW-1:0] hold_flags;
    logic [FLW-1:0] calc_flags;
    logic [DW-1:0]  out_byte;
    logic           take_in, take_out, finish_in;

    pio_decode u_dec (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    pio_flagcalc #(.DW(DW)) u_flg (
        .old_flags_i (hold_flags),
        .data_i      (port_rd_data_i),
        .new_flags_o (calc_flags)
    );

    pio_outsel #(.DW(DW), .NREG(NREG)) u_sel (
        .regs_i (regs_i),
        .sel_i  (dec.field[SELW-1:0]),
        .data_o (out_byte)
    );

    always_comb begin
        take_in   = (state == ST_IDLE) && issue_i && (dec.kind == K_IN);
        take_out  = (state == ST_IDLE) && issue_i && (dec.kind == K_OUT);
        finish_in = (state == ST_WAIT_IN) && port_rd_valid_i;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (take_in)   state_nx = ST_WAIT_IN;
            ST_WAIT_IN: if (finish_in) state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_field   <= '0;
            hold_flags   <= '0;
            flags_we_o   <= 1'b0;
            flags_o      <= '0;
            reg_we_o     <= 1'b0;
            reg_sel_o    <= '0;
            reg_wdata_o  <= '0;
            port_wr_o    <= 1'b0;
            port_wdata_o <= '0;
        end else begin
            flags_we_o <= 1'b0;
            reg_we_o   <= 1'b0;
            port_wr_o  <= 1'b0;
            if (take_in) begin
                hold_field <= dec.field[SELW-1:0];
                hold_flags <= flags_i;
            end
            if (take_out) begin
                port_wr_o    <= 1'b1;
                port_wdata_o <= out_byte;
            end
            if (finish_in) begin
                flags_we_o  <= 1'b1;
                flags_o     <= calc_flags;
                reg_sel_o   <= hold_field;
                reg_wdata_o <= port_rd_data_i;
                reg_we_o    <= (hold_field != NOREG_FIELD[SELW-1:0]);
            end
        end
    end

    assign busy_o = (state == ST_WAIT_IN);

    assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !port_rd_valid_i) |=> busy_o);

    assert_flags_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> $past(busy_o && port_rd_valid_i));

    assert_sign_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> (flags_o[F_SGN] == reg_wdata_o[DW-1]) &&
                       (flags_o[F_ZER] == (reg_wdata_o == '0)));

    assert_hc_sub_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> !flags_o[F_HC] && !flags_o[F_SUB]);

    assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> (flags_o[F_PAR] == ~(^reg_wdata_o)));

    assert_reg_with_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> flags_we_o && (reg_sel_o != NOREG_FIELD[SELW-1:0]));

    assert_out_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_o |-> $past(issue_i && !busy_o));

    assert_out_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({port_wr_o, flags_we_o}));
endmodule

// File: tb/sim_pio_flag_unit.sv
module sim_pio_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  flags_i = '0;
    logic [63:0] regs_i = '0;
    logic        port_rd_valid_i = 1'b0;
    logic [7:0]  port_rd_data_i = '0;
    logic        busy_o, flags_we_o, reg_we_o, port_wr_o;
    logic [7:0]  flags_o, reg_wdata_o, port_wdata_o;
    logic [2:0]  reg_sel_o;

    pio_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .flags_i(flags_i), .regs_i(regs_i), .port_rd_valid_i(port_rd_valid_i),
        .port_rd_data_i(port_rd_data_i), .busy_o(busy_o), .flags_we_o(flags_we_o),
        .flags_o(flags_o), .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o),
        .reg_wdata_o(reg_wdata_o), .port_wr_o(port_wr_o), .port_wdata_o(port_wdata_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        int         due;
        bit         is_in;
        logic [7:0] flg;
        bit         rwe;
        logic [2:0] sel;
        logic [7:0] data;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_flags(input logic [7:0] old, input logic [7:0] d);
        ref_flags = {d[7], (d == 8'h00), old[5], 1'b0, old[3], ~(^d), 1'b0, old[0]};
    endfunction

    exp_t e;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q.pop_front();
                if (e.is_in) begin
                    chk(flags_we_o == 1'b1, "R3", "flags_we", flags_we_o, 1);
                    chk(flags_o == e.flg, "R3/R4/R5/R6", "flags", flags_o, e.flg);
                    chk(reg_we_o == e.rwe, "R7", "reg_we", reg_we_o, e.rwe);
                    if (e.rwe) begin
                        chk(reg_sel_o == e.sel, "R7", "reg_sel", reg_sel_o, e.sel);
                        chk(reg_wdata_o == e.data, "R7", "reg_wdata", reg_wdata_o, e.data);
                    end
                    chk(port_wr_o == 1'b0, "R3", "port_wr", port_wr_o, 0);
                end else begin
                    chk(port_wr_o == 1'b1, "R8", "port_wr", port_wr_o, 1);
                    chk(port_wdata_o == e.data, "R8/R9", "port_wdata", port_wdata_o, e.data);
                    chk(!flags_we_o && !reg_we_o, "R10", "we", {flags_we_o, reg_we_o}, 0);
                end
            end else if (flags_we_o || reg_we_o || port_wr_o) begin
                chk(1'b0, "R11/R12", "unexpected pulse",
                    {flags_we_o, reg_we_o, port_wr_o}, 0);
            end
        end
    end

    task automatic do_in(input logic [2:0] fld, input logic [7:0] old,
                         input logic [7:0] d, input int delay);
        exp_t x;
        issue_i  = 1'b1;
        opcode_i = {2'b01, fld, 3'b000};
        flags_i  = old;
        @(negedge clk);
        issue_i = 1'b0;
        flags_i = ~old;
        chk(busy_o == 1'b1, "R2", "busy after issue", busy_o, 1);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(busy_o == 1'b1, "R2", "busy while waiting", busy_o, 1);
        end
        port_rd_valid_i = 1'b1;
        port_rd_data_i  = d;
        x.due = cyc + 1; x.is_in = 1'b1; x.flg = ref_flags(old, d);
        x.rwe = (fld != 3'd6); x.sel = fld; x.data = d;
        q.push_back(x);
        @(negedge clk);
        port_rd_valid_i = 1'b0;
        chk(busy_o == 1'b0, "R2", "busy after data", busy_o, 0);
        @(negedge clk);
    endtask

    task automatic do_out(input logic [2:0] fld);
        exp_t x;
        issue_i  = 1'b1;
        opcode_i = {2'b01, fld, 3'b001};
        x.due = cyc + 1; x.is_in = 1'b0; x.flg = '0; x.rwe = 1'b0; x.sel = fld;
        x.data = (fld == 3'd6) ? 8'h00 : regs_i[fld*8 +: 8];
        q.push_back(x);
        @(negedge clk);
        issue_i = 1'b0;
        chk(busy_o == 1'b0, "R10", "busy after out", busy_o, 0);
        @(negedge clk);
    endtask

    initial begin
        regs_i = 64'h7A_5C_33_D4_E1_0F_96_18;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(busy_o == 1'b0, "R1", "busy", busy_o, 0);
        chk(!flags_we_o && !reg_we_o && !port_wr_o, "R1", "pulses",
            {flags_we_o, reg_we_o, port_wr_o}, 0);
        @(negedge clk);

        do_in(3'd7, 8'hFF, 8'h00, 0);  // R3 zero, R5 even, R6 keep
        do_in(3'd0, 8'h00, 8'h80, 2);  // R3 sign, R5 odd
        do_in(3'd6, 8'h29, 8'h03, 1);  // R7 flags-only
        do_in(3'd3, 8'h12, 8'hA5, 3);  // R4 cleared
        do_in(3'd5, 8'hD7, 8'h7F, 0);  // R5 odd count

        do_out(3'd2);                  // R8
        do_out(3'd7);                  // R8
        do_out(3'd6);                  // R9 zero constant

        // R11: issue while busy is ignored
        issue_i = 1'b1; opcode_i = 8'h40; flags_i = 8'h01;
        @(negedge clk);
        opcode_i = 8'h79;
        @(negedge clk);
        issue_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "busy kept", busy_o, 1);
        begin
            exp_t x;
            port_rd_valid_i = 1'b1; port_rd_data_i = 8'h01;
            x.due = cyc + 1; x.is_in = 1'b1; x.flg = ref_flags(8'h01, 8'h01);
            x.rwe = 1'b1; x.sel = 3'd0; x.data = 8'h01;
            q.push_back(x);
        end
        @(negedge clk);
        port_rd_valid_i = 1'b0;
        @(negedge clk);

        // R11: opcodes outside both forms
        issue_i = 1'b1; opcode_i = 8'h44;
        @(negedge clk);
        opcode_i = 8'h72;
        @(negedge clk);
        issue_i = 1'b0;
        chk(busy_o == 1'b0, "R11", "busy on invalid", busy_o, 0);

        // R12: stray read strobe in idle
        port_rd_valid_i = 1'b1; port_rd_data_i = 8'h55;
        @(negedge clk);
        port_rd_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R12", "busy on stray", busy_o, 0);
        chk(q.size() == 0, "R3/R8", "results outstanding", q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule